// File: doc/BRIEF.md
# ADC Continuous-Conversion Serial Reader

This block is the host-side engine that collects results from a delta-sigma converter running in continuous-conversion mode. The link has three wires: a serial clock driven by the host, a command line driven by the host, and a data line driven by the converter. When the converter has a fresh result, it pulls its data line low. The engine watches for that level through a synchronizer. It then runs one fixed transfer: eight command clocks that clear the converter's ready flag, followed by twenty-four clocks that shift the result in, most significant bit first.

At the end of each transfer the word appears on a parallel bus together with a one-clock valid strobe. In 24-bit format the full word is the result. In 16-bit format the upper sixteen bits are the result and the trailing byte is decoded as status. That byte holds a fixed marker nibble, a two-bit channel number, an oscillation flag and an overflow flag. A damaged marker raises a framing error, and the word is still delivered. The serial clock rate is set at run time by a half-period input.

Top module: `adc_stream_reader`

## Requirements
- R1: While and after synchronous reset (`rst` high), the engine is idle. Serial clock and command line are low, and every result output and the valid strobe are zero.
- R2: A transfer starts only after the data line has been seen high while idle and then seen low, after synchronization, on two consecutive system clocks. A low pulse of one system clock starts nothing. A line that stays low after a transfer starts no second transfer until it has gone high again.
- R3: The serial clock idles low. During a transfer its period is 2*max(`halfDiv`,1) system clocks, so the divide ratio is never below 2.
- R4: Every transfer has exactly 32 rising serial-clock edges: 8 command clocks and then 24 data clocks.
- R5: The command line changes only together with a falling serial-clock edge. It carries the command word MSB first during the first eight clocks and zero after that. With the default all-zero command it stays low.
- R6: The data line is sampled on each rising serial-clock edge of the data phase. In 24-bit format (`mode16`=0), `dataOut` is the 24 sampled bits with the first sample as bit 23.
- R7: In 16-bit format (`mode16`=1), `dataOut[15:0]` holds the first 16 sampled bits (first as bit 15) and `dataOut[23:16]` is zero. In the final byte, arrival bits 5..6 go to `chanOut[1:0]` (first as bit 1), bit 7 goes to `oscDet` and bit 8 goes to `ovfl`.
- R8: In 16-bit format, `frameErr` is set when the first four bits of the final byte are not 1,1,1,0 in arrival order. The word is delivered either way.
- R9: `dataValid` is high for exactly one system clock after the last data bit, with the serial clock back low. All result outputs hold their values until the next strobe.
- R10: In 24-bit format, `chanOut`, `oscDet`, `ovfl` and `frameErr` are zero with each word. The format is taken from `mode16` when the transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| halfDiv | input | DIV_W | Serial-clock half period in system clocks (0 acts as 1) |
| mode16 | input | 1 | 1 selects 16-bit result with status byte, 0 selects 24-bit result |
| sdo | input | 1 | Converter data line; low while idle means result ready |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Command line to the converter |
| dataOut | output | WORD_LEN | Received result word |
| chanOut | output | 2 | Channel number from the status byte |
| oscDet | output | 1 | Oscillation-detect flag from the status byte |
| ovfl | output | 1 | Overflow flag from the status byte |
| frameErr | output | 1 | Status marker nibble mismatch |
| dataValid | output | 1 | One-clock strobe marking a new word |

## Verification
The bench builds the block with a 4-bit half-period input and the default 8 command bits, 24-bit word and all-zero command word. Within that range it can run the serial clock at the minimum divide of two, check that a zero setting is clamped to the minimum, and run a slower setting of three. These cases exercise both sampling and command shifting at several clock ratios. The converter model drives each bit after a falling edge, so the bench also covers marker-correct and marker-damaged status bytes, a one-clock ready glitch, and a ready line left stuck low after a read.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef struct packed {
    logic loadCmd;
    logic sampleBit;
    logic shiftCmd;
    logic publish;
  } rdStrobe_t;

  typedef enum logic {
    ST_IDLE,
    ST_XFER
  } rdState_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CMD_LEN  = 8,
  parameter int WORD_LEN = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             sdoRaw,
  output logic             sclk,
  output rdStrobe_t        strobe
);

  localparam int TOTAL = CMD_LEN + WORD_LEN;
  localparam int CNT_W = $clog2(TOTAL);

  rdState_t   state;
  logic [2:0] sdoSync;
  logic       armed;
  logic       sclkReg;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] halfEff;
  logic       lastDiv;
  logic       readyLow;

  // two synchronizer stages plus one history stage
  always_ff @(posedge clk) begin
    if (rst) sdoSync <= '1;
    else     sdoSync <= {sdoSync[1:0], sdoRaw};
  end

  assign readyLow = !sdoSync[1] && !sdoSync[2];
  assign halfEff  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign lastDiv  = (divCnt == DIV_W'(halfEff - DIV_W'(1)));

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.loadCmd = armed && readyLow;
      ST_XFER: begin
        if (lastDiv) begin
          if (!sclkReg) begin
            strobe.sampleBit = (bitCnt >= CNT_W'(CMD_LEN));
          end else begin
            strobe.shiftCmd = 1'b1;
            strobe.publish  = (bitCnt == CNT_W'(TOTAL - 1));
          end
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      armed   <= 1'b0;
      sclkReg <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclkReg <= 1'b0;
          divCnt  <= '0;
          bitCnt  <= '0;
          if (strobe.loadCmd) begin
            state <= ST_XFER;
            armed <= 1'b0;
          end else if (sdoSync[1]) begin
            armed <= 1'b1;
          end
        end
        ST_XFER: begin
          if (lastDiv) begin
            divCnt  <= '0;
            sclkReg <= !sclkReg;
            if (sclkReg) begin
              if (strobe.publish) state <= ST_IDLE;
              else                bitCnt <= bitCnt + CNT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkReg;

endmodule

// File: rtl/adc_rd_datapath.sv
`timescale 1ns/1ps
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int                  CMD_LEN  = 8,
  parameter int                  WORD_LEN = 24,
  parameter logic [CMD_LEN-1:0]  CMD_WORD = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  rdStrobe_t           strobe,
  input  logic                sdoRaw,
  input  logic                mode16,
  output logic                sdi,
  output logic                modeLat,
  output logic [WORD_LEN-1:0] dataOut,
  output logic [1:0]          chanOut,
  output logic                oscDet,
  output logic                ovfl,
  output logic                frameErr,
  output logic                dataValid
);

  localparam int RES16 = WORD_LEN - 8;

  logic [CMD_LEN-1:0]  cmdReg;
  logic [WORD_LEN-1:0] shReg;
  logic                markerBad;

  assign markerBad = (shReg[7:4] != 4'b1110);

  // command shifter and mode latch
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg  <= '0;
      sdi     <= 1'b0;
      modeLat <= 1'b0;
    end else if (strobe.loadCmd) begin
      sdi     <= CMD_WORD[CMD_LEN-1];
      cmdReg  <= {CMD_WORD[CMD_LEN-2:0], 1'b0};
      modeLat <= mode16;
    end else if (strobe.shiftCmd) begin
      sdi     <= cmdReg[CMD_LEN-1];
      cmdReg  <= {cmdReg[CMD_LEN-2:0], 1'b0};
    end
  end

  // result shifter
  always_ff @(posedge clk) begin
    if (rst)                  shReg <= '0;
    else if (strobe.loadCmd)  shReg <= '0;
    else if (strobe.sampleBit) shReg <= {shReg[WORD_LEN-2:0], sdoRaw};
  end

  // output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      chanOut   <= '0;
      oscDet    <= 1'b0;
      ovfl      <= 1'b0;
      frameErr  <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.publish;
      if (strobe.publish) begin
        if (modeLat) begin
          dataOut  <= {{8{1'b0}}, shReg[WORD_LEN-1:8]};
          chanOut  <= shReg[3:2];
          oscDet   <= shReg[1];
          ovfl     <= shReg[0];
          frameErr <= markerBad;
        end else begin
          dataOut  <= shReg;
          chanOut  <= '0;
          oscDet   <= 1'b0;
          ovfl     <= 1'b0;
          frameErr <= 1'b0;
        end
      end
    end
  end

  // the 16-bit layout needs room for at least one result byte
  if (RES16 < 8) begin : g_badlen
    initial $error("WORD_LEN too short for status decode");
  end

endmodule

// File: rtl/adc_stream_reader.sv
`timescale 1ns/1ps
module adc_stream_reader
  import adc_rd_pkg::*;
#(
  parameter int                 DIV_W    = 8,
  parameter int                 CMD_LEN  = 8,
  parameter int                 WORD_LEN = 24,
  parameter logic [CMD_LEN-1:0] CMD_WORD = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    halfDiv,
  input  logic                mode16,
  input  logic                sdo,
  output logic                sclk,
  output logic                sdi,
  output logic [WORD_LEN-1:0] dataOut,
  output logic [1:0]          chanOut,
  output logic                oscDet,
  output logic                ovfl,
  output logic                frameErr,
  output logic                dataValid
);

  rdStrobe_t strobe;
  logic      modeLat;

  adc_rd_ctrl #(
    .DIV_W(DIV_W), .CMD_LEN(CMD_LEN), .WORD_LEN(WORD_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .halfDiv(halfDiv), .sdoRaw(sdo),
    .sclk(sclk), .strobe(strobe)
  );

  adc_rd_datapath #(
    .CMD_LEN(CMD_LEN), .WORD_LEN(WORD_LEN), .CMD_WORD(CMD_WORD)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .sdoRaw(sdo), .mode16(mode16),
    .sdi(sdi), .modeLat(modeLat), .dataOut(dataOut), .chanOut(chanOut),
    .oscDet(oscDet), .ovfl(ovfl), .frameErr(frameErr), .dataValid(dataValid)
  );

endmodule

// File: rtl/adc_rd_checker.sv
`timescale 1ns/1ps
module adc_rd_checker #(
  parameter int WORD_LEN = 24,
  parameter int TOTAL    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                sclk,
  input logic                sdi,
  input logic                modeLat,
  input logic [WORD_LEN-1:0] dataOut,
  input logic [1:0]          chanOut,
  input logic                frameErr,
  input logic                dataValid
);

  logic       sclkQ;
  logic [7:0] riseCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ   <= 1'b0;
      riseCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (dataValid)          riseCnt <= '0;
      else if (sclk && !sclkQ) riseCnt <= riseCnt + 8'd1;
    end
  end

  p_idle_sclk_r3: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> !sclk);

  p_edge_total_r4: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> riseCnt == 8'(TOTAL));

  p_sdi_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdi) |-> $fell(sclk));

  p_single_valid_r9: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> $stable(dataOut));

  p_clean_24_r10: assert property (@(posedge clk) disable iff (rst)
    (dataValid && !modeLat) |-> (!frameErr && chanOut == 2'b00));

endmodule

bind adc_stream_reader adc_rd_checker #(
  .WORD_LEN(WORD_LEN), .TOTAL(CMD_LEN + WORD_LEN)
) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .modeLat(modeLat),
  .dataOut(dataOut), .chanOut(chanOut), .frameErr(frameErr),
  .dataValid(dataValid)
);

// File: tb/adc_stream_reader_bench.sv
`timescale 1ns/1ps
module adc_stream_reader_bench;

  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] halfDiv = '0;
  logic             mode16 = 1'b0;
  logic             sdo = 1'b1;
  logic             sclk, sdi, oscDet, ovfl, frameErr, dataValid;
  logic [23:0]      dataOut;
  logic [1:0]       chanOut;

  adc_stream_reader #(.DIV_W(DIV_W)) u_adc_stream_reader (
    .clk(clk), .rst(rst), .halfDiv(halfDiv), .mode16(mode16), .sdo(sdo),
    .sclk(sclk), .sdi(sdi), .dataOut(dataOut), .chanOut(chanOut),
    .oscDet(oscDet), .ovfl(ovfl), .frameErr(frameErr), .dataValid(dataValid)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [23:0] d;
    logic [1:0]  c;
    logic        o;
    logic        v;
    logic        f;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  bit          sdiHigh = 0;
  logic        sclkPrev = 1'b0;
  logic        validPrev = 1'b0;
  int          riseSeen = 0;
  logic [23:0] lastData = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected words as the design presents them
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk && !sclkPrev) riseSeen++;
      if (sdi) sdiHigh = 1;
      if (dataValid) begin
        chk(riseSeen == 32, "R4", "rising edges per read", riseSeen, 32);
        riseSeen = 0;
        chk(!validPrev, "R9", "strobe width", validPrev, 0);
        chk(!sclk, "R9", "sclk low at strobe", sclk, 0);
        if (q.size() == 0) begin
          chk(0, "R6", "unexpected word", dataOut, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(dataOut == e.d, e.tag, "dataOut", dataOut, e.d);
          chk(chanOut == e.c, e.tag, "chanOut", chanOut, e.c);
          chk(oscDet == e.o,  e.tag, "oscDet", oscDet, e.o);
          chk(ovfl == e.v,    e.tag, "ovfl", ovfl, e.v);
          chk(frameErr == e.f, "R8", "frameErr", frameErr, e.f);
        end
        lastData = dataOut;
      end
    end
    sclkPrev  = sclk;
    validPrev = dataValid;
  end

  // converter model: one result per call
  task automatic xfer(input logic [23:0] w, input logic m16,
                      input logic [DIV_W-1:0] h, input bit keepLow);
    exp_t   e;
    int     heff;
    longint tf1, tf2;
    heff = (h == 0) ? 1 : int'(h);
    tf1 = 0;
    tf2 = 0;
    @(negedge clk);
    mode16  = m16;
    halfDiv = h;
    if (m16) begin
      e.d = {8'h00, w[23:8]};
      e.c = w[3:2];
      e.o = w[1];
      e.v = w[0];
      e.f = (w[7:4] != 4'b1110);
      e.tag = "R7";
    end else begin
      e.d = w;
      e.c = 2'b00;
      e.o = 1'b0;
      e.v = 1'b0;
      e.f = 1'b0;
      e.tag = "R10";
    end
    q.push_back(e);
    sdiHigh = 0;
    @(negedge clk) sdo = 1'b0;
    for (int n = 1; n <= 32; n++) begin
      @(negedge sclk);
      if (n == 1) tf1 = $time;
      if (n == 2) tf2 = $time;
      if (n >= 8 && n <= 31) sdo = w[31-n];
      else if (n == 32) sdo = keepLow ? 1'b0 : 1'b1;
    end
    repeat (4) @(negedge clk);
    chk((tf2 - tf1) == longint'(2 * heff * 20), "R3", "sclk period ns",
        tf2 - tf1, 2 * heff * 20);
    chk(!sdiHigh, "R5", "sdi stayed low", sdiHigh, 0);
  endtask

  initial begin
    bit moved;
    repeat (3) @(negedge clk);
    chk(!sclk && !sdi, "R1", "sclk/sdi in reset", {sclk, sdi}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sclk && !sdi, "R1", "sclk/sdi after reset", {sclk, sdi}, 0);
    chk(dataOut == 0 && !dataValid, "R1", "outputs after reset", dataOut, 0);
    chk(chanOut == 0 && !oscDet && !ovfl && !frameErr, "R1", "status after reset",
        {chanOut, oscDet, ovfl, frameErr}, 0);

    // R6 24-bit word at divide-by-four
    xfer(24'hA5C3F1, 1'b0, 4'd2, 1'b0);
    // R3 zero half period clamps to divide-by-two
    xfer(24'h800001, 1'b0, 4'd0, 1'b0);
    // R7 16-bit word with good marker, channel 2, osc set
    xfer({16'h1234, 8'b1110_10_1_0}, 1'b1, 4'd3, 1'b0);
    // R8 16-bit word with damaged marker
    xfer({16'hBEEF, 8'b0110_01_0_1}, 1'b1, 4'd1, 1'b0);

    // R9 outputs hold after strobe
    repeat (20) @(negedge clk);
    chk(dataOut == lastData, "R9", "dataOut held", dataOut, lastData);
    chk(dataOut == 24'h00BEEF, "R9", "held value", dataOut, 24'h00BEEF);

    // R2 one-clock low glitch starts nothing
    @(negedge clk) sdo = 1'b0;
    @(negedge clk) sdo = 1'b1;
    moved = 0;
    repeat (60) @(negedge clk) if (sclk) moved = 1;
    chk(!moved, "R2", "glitch started transfer", moved, 0);

    // R2 line left low after a read starts no second read
    xfer(24'h5A5A5A, 1'b0, 4'd1, 1'b1);
    moved = 0;
    repeat (200) @(negedge clk) if (sclk) moved = 1;
    chk(!moved, "R2", "stuck-low restart", moved, 0);
    sdo = 1'b1;
    repeat (6) @(negedge clk);
    xfer(24'h0F0F0F, 1'b1, 4'd2, 1'b0);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9", "words pending", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R4 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule